// File: doc/BRIEF.md
# Floating-point escape instruction byte-stream decoder

This block sits in an instruction front end and reads a byte stream, one byte per accepted cycle, over a valid/ready input. It picks out the floating-point escape instructions, which start with a first byte from D8h to DFh, and drops every other first byte with a one-cycle indication. After the escape byte it reads the ModR/M byte. A ModR/M byte below C0h selects the memory form: bits 5:3 choose the operation, and the addressing bytes that follow are consumed. A ModR/M byte of C0h or above selects the register form: the whole byte chooses the operation, and no further bytes follow.

Each recognized instruction produces one registered record on a valid/ready output. The record holds the escape byte, an operation code, a memory flag, the stack register index, the displacement as a little-endian word, and a reserved flag. The operation map covers the D8h group and the double-precision load in the DDh group. Every other map position is reported as reserved. While a record waits for the consumer, the input stalls.

Top module: `fpu_escape_decoder`

## Requirements
- R1: A first byte outside D8h..DFh is consumed. It makes no record and raises `not_esc` for exactly the one cycle after it is accepted.
- R2: A ModR/M byte below C0h gives `out_is_mem`=1 and `out_sti`=0. A ModR/M byte of C0h or above gives `out_is_mem`=0, `out_sti`=ModR/M[2:0], `out_disp`=0, and ends the instruction.
- R3: With escape byte D8h, the operation code is ModR/M[5:3]+1 in both forms: 1 add, 2 multiply, 3 compare, 4 compare-and-pop, 5 subtract, 6 reverse subtract, 7 divide, 8 reverse divide.
- R4: With escape byte DDh, a memory-form ModR/M with bits 5:3 = 000 gives operation code 9, the double-precision load.
- R5: Every other escape/ModR/M combination gives operation code 0 and `out_reserved`=1. Its address bytes are still consumed, and a record is still emitted.
- R6: In memory form, the address bytes depend on ModR/M. mod (bits 7:6) = 01 adds one displacement byte, sign-extended. mod = 10 adds four displacement bytes. mod = 00 with r/m (bits 2:0) = 101 adds four displacement bytes. r/m = 100 adds one SIB byte before any displacement. Any other ModR/M adds no address bytes.
- R7: A four-byte displacement is assembled little-endian: the first byte received becomes `out_disp`[7:0].
- R8: `out_valid` rises in the cycle after the last byte of an instruction is accepted, and not earlier.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and every record field holds its value.
- R10: A synchronous reset discards a partly collected instruction. The next byte is then treated as a first byte.
- R11: In the cycle after `out_valid`&&`out_ready`, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Decoder can accept a byte |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_esc | output | 8 | Escape byte of the instruction |
| out_op | output | 4 | Operation code (0 none, 1..8 D8h group, 9 double load) |
| out_is_mem | output | 1 | Memory-form operand |
| out_sti | output | 3 | Stack register index for register form |
| out_disp | output | 32 | Displacement, little-endian assembled |
| out_reserved | output | 1 | Map position is reserved |
| not_esc | output | 1 | One-cycle pulse for a dropped non-escape byte |

## Verification
Each result has a fixed due cycle. The record appears one cycle after the final byte of an instruction is accepted, and `not_esc` appears one cycle after a dropped byte is accepted. Draining a record frees the input one cycle after the handshake. The bench drives and samples on the falling edge. When a byte task returns, the edge that accepted the byte has just passed, so the registered results are checked at that point. `out_valid` is also checked to be low after each byte that comes before the last one.

// File: rtl/escdec_pkg.sv
package escdec_pkg;
  localparam int BYTE_W     = 8;
  localparam int DISP_W     = 32;
  localparam int DISP_BYTES = DISP_W / BYTE_W;
  localparam int LEN_W      = 3;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_FADD    = 4'd1,
    OP_FMUL    = 4'd2,
    OP_FCOM    = 4'd3,
    OP_FCOMP   = 4'd4,
    OP_FSUB    = 4'd5,
    OP_FSUBR   = 4'd6,
    OP_FDIV    = 4'd7,
    OP_FDIVR   = 4'd8,
    OP_FLD_DBL = 4'd9
  } esc_op_e;

  // Operation lookup: D8h group is indexed by bits 5:3 in either form.
  function automatic esc_op_e op_lookup(input logic [7:0] esc, input logic [7:0] mrm);
    logic [2:0] sel;
    sel = mrm[5:3];
    if (esc == 8'hD8) return esc_op_e'({1'b0, sel} + 4'd1);
    if (esc == 8'hDD && mrm[7:6] != 2'b11 && sel == 3'd0) return OP_FLD_DBL;
    return OP_NONE;
  endfunction

  // Number of displacement bytes for a memory-form ModR/M.
  function automatic logic [LEN_W-1:0] addr_disp_len(input logic [7:0] mrm);
    case (mrm[7:6])
      2'b00:   return (mrm[2:0] == 3'b101) ? LEN_W'(DISP_BYTES) : '0;
      2'b01:   return LEN_W'(1);
      2'b10:   return LEN_W'(DISP_BYTES);
      default: return '0;
    endcase
  endfunction

  // Final displacement: short form is sign-extended, long form is the shifted word.
  function automatic logic [DISP_W-1:0] disp_finish(input logic [DISP_W-1:0] word,
                                                    input logic [BYTE_W-1:0] b,
                                                    input logic [LEN_W-1:0] len);
    if (len == LEN_W'(1)) return {{(DISP_W-BYTE_W){b[BYTE_W-1]}}, b};
    return word;
  endfunction
endpackage

// File: rtl/escdec_modrm_map.sv
module escdec_modrm_map
  import escdec_pkg::*;
(
  input  logic [BYTE_W-1:0] esc_byte,
  input  logic [BYTE_W-1:0] modrm,
  output esc_op_e           op,
  output logic              is_mem,
  output logic              reserved,
  output logic [2:0]        sti,
  output logic              sib_needed,
  output logic [LEN_W-1:0]  disp_len
);
  assign is_mem     = (modrm[7:6] != 2'b11);
  assign op         = op_lookup(esc_byte, modrm);
  assign reserved   = (op == OP_NONE);
  assign sti        = is_mem ? 3'd0 : modrm[2:0];
  assign sib_needed = is_mem && (modrm[2:0] == 3'b100);
  assign disp_len   = is_mem ? addr_disp_len(modrm) : '0;

  always_comb begin
    p_regform_noaddr_r2: assert (is_mem || (!sib_needed && disp_len == '0))
      else $error("register form must not request address bytes");
  end
endmodule

// File: rtl/escdec_disp_collect.sv
module escdec_disp_collect
  import escdec_pkg::*;
(
  input  logic              clk,
  input  logic              clear,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [DISP_W-1:0] next_word
);
  logic [DISP_W-1:0] acc_q;

  // New byte enters at the top, so the first byte ends in the lowest lane.
  assign next_word = {byte_in, acc_q[DISP_W-1:BYTE_W]};

  always_ff @(posedge clk) begin
    if (clear)         acc_q <= '0;
    else if (shift_en) acc_q <= next_word;
  end
endmodule

// File: rtl/fpu_escape_decoder.sv
module fpu_escape_decoder
  import escdec_pkg::*;
#(
  parameter logic [7:0] ESC_LO = 8'hD8,
  parameter logic [7:0] ESC_HI = 8'hDF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_esc,
  output logic [3:0]  out_op,
  output logic        out_is_mem,
  output logic [2:0]  out_sti,
  output logic [31:0] out_disp,
  output logic        out_reserved,
  output logic        not_esc
);
  typedef enum logic [2:0] {S_IDLE, S_MODRM, S_SIB, S_DISP, S_OUT} st_e;

  st_e               state_q, state_d;
  logic [BYTE_W-1:0] esc_q, modrm_q;
  logic [LEN_W-1:0]  len_q, left_q;
  logic              not_esc_q;

  // Named internal events
  logic accept, is_esc, handoff;
  logic fin_modrm, fin_sib, fin_disp, finish;
  logic [BYTE_W-1:0] map_mrm;
  logic [DISP_W-1:0] disp_word, disp_final;

  esc_op_e          m_op;
  logic             m_is_mem, m_rsv, m_sib;
  logic [2:0]       m_sti;
  logic [LEN_W-1:0] m_len;

  assign in_ready  = (state_q != S_OUT);
  assign out_valid = (state_q == S_OUT);
  assign accept    = in_valid && in_ready;
  assign handoff   = out_valid && out_ready;
  assign is_esc    = (in_byte >= ESC_LO) && (in_byte <= ESC_HI);
  assign map_mrm   = (state_q == S_MODRM) ? in_byte : modrm_q;

  escdec_modrm_map u_map (
    .esc_byte  (esc_q),
    .modrm     (map_mrm),
    .op        (m_op),
    .is_mem    (m_is_mem),
    .reserved  (m_rsv),
    .sti       (m_sti),
    .sib_needed(m_sib),
    .disp_len  (m_len)
  );

  escdec_disp_collect u_disp (
    .clk      (clk),
    .clear    (rst || (accept && state_q == S_IDLE)),
    .shift_en (accept && state_q == S_DISP),
    .byte_in  (in_byte),
    .next_word(disp_word)
  );

  assign fin_modrm  = accept && (state_q == S_MODRM) && !m_sib && (m_len == '0);
  assign fin_sib    = accept && (state_q == S_SIB) && (len_q == '0);
  assign fin_disp   = accept && (state_q == S_DISP) && (left_q == LEN_W'(1));
  assign finish     = fin_modrm || fin_sib || fin_disp;
  assign disp_final = fin_disp ? disp_finish(disp_word, in_byte, len_q) : '0;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept && is_esc) state_d = S_MODRM;
      S_MODRM: if (accept) state_d = fin_modrm ? S_OUT : (m_sib ? S_SIB : S_DISP);
      S_SIB:   if (accept) state_d = fin_sib ? S_OUT : S_DISP;
      S_DISP:  if (fin_disp) state_d = S_OUT;
      S_OUT:   if (handoff) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      esc_q        <= '0;
      modrm_q      <= '0;
      len_q        <= '0;
      left_q       <= '0;
      not_esc_q    <= 1'b0;
      out_esc      <= '0;
      out_op       <= '0;
      out_is_mem   <= 1'b0;
      out_sti      <= '0;
      out_disp     <= '0;
      out_reserved <= 1'b0;
    end else begin
      state_q   <= state_d;
      not_esc_q <= accept && (state_q == S_IDLE) && !is_esc;
      if (accept && state_q == S_IDLE) esc_q <= in_byte;
      if (accept && state_q == S_MODRM) begin
        modrm_q <= in_byte;
        len_q   <= m_len;
        left_q  <= m_len;
      end
      if (accept && state_q == S_DISP) left_q <= left_q - LEN_W'(1);
      if (finish) begin
        out_esc      <= esc_q;
        out_op       <= m_op;
        out_is_mem   <= m_is_mem;
        out_sti      <= m_sti;
        out_disp     <= disp_final;
        out_reserved <= m_rsv;
      end
    end
  end

  assign not_esc = not_esc_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_disp)
                                && $stable(out_esc) && $stable(out_sti))
    else $error("record changed while stalled");
  p_stall_input_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready)
    else $error("input open while record pending");
  p_rsv_noop_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_reserved |-> out_op == 4'd0)
    else $error("reserved record carries an operation");
  p_reg_nodisp_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_mem |-> out_disp == '0)
    else $error("register form with displacement");
  p_drain_r11: assert property (@(posedge clk) disable iff (rst)
    handoff |=> !out_valid && in_ready)
    else $error("record not released after handshake");
  p_notesc_norec_r1: assert property (@(posedge clk) disable iff (rst)
    not_esc |-> !out_valid)
    else $error("dropped byte produced a record");
endmodule

// File: tb/fpu_escape_decoder_bench.sv
module fpu_escape_decoder_bench;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, out_valid, out_is_mem, out_reserved, not_esc;
  logic [7:0] out_esc;
  logic [3:0] out_op;
  logic [2:0] out_sti;
  logic [31:0] out_disp;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  fpu_escape_decoder u_fpu_escape_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_esc(out_esc), .out_op(out_op),
    .out_is_mem(out_is_mem), .out_sti(out_sti), .out_disp(out_disp),
    .out_reserved(out_reserved), .not_esc(not_esc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference operation code, written as an explicit table walk.
  function automatic int ref_op(input int esc, input int mrm);
    int grp;
    grp = (mrm / 8) % 8;
    case (esc)
      'hD8: return grp + 1;
      'hDD: return (mrm < 'hC0 && grp == 0) ? 9 : 0;
      default: return 0;
    endcase
  endfunction

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(input logic [7:0] b);
    in_byte = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take(input string req);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R11", {req, " valid low after handshake"}, out_valid, 0);
    chk(in_ready == 1'b1, "R11", {req, " input reopened"}, in_ready, 1);
  endtask

  // seq holds up to six bytes, first byte in the top lane.
  task automatic do_insn(input int n, input logic [47:0] seq, input int emem, input int esti,
                         input logic [31:0] edisp, input string req);
    int eop;
    eop = ref_op(seq[47:40], seq[39:32]);
    for (int k = 0; k < n; k++) begin
      send(seq[47-8*k -: 8]);
      if (k < n-1) chk(out_valid == 1'b0, "R8", {req, " early record"}, out_valid, 0);
    end
    chk(out_valid == 1'b1, "R8", {req, " record due"}, out_valid, 1);
    chk(out_op == 4'(eop), req, "op", out_op, eop);
    chk(out_reserved == (eop == 0), "R5", {req, " reserved flag"}, out_reserved, eop == 0);
    chk(out_is_mem == 1'(emem), "R2", {req, " mem flag"}, out_is_mem, emem);
    chk(out_sti == 3'(esti), "R2", {req, " sti"}, out_sti, esti);
    chk(out_disp == edisp, req, "disp", out_disp, edisp);
    chk(out_esc == seq[47:40], req, "esc", out_esc, seq[47:40]);
    take(req);
  endtask

  task automatic t_reset_state();
    chk(out_valid == 0 && in_ready == 1 && not_esc == 0, "R10", "reset state",
        {out_valid, in_ready, not_esc}, 3'b010);
  endtask

  task automatic t_not_escape();
    send(8'h90);
    chk(not_esc == 1, "R1", "not_esc pulse", not_esc, 1);
    chk(out_valid == 0, "R1", "no record", out_valid, 0);
    @(negedge clk);
    chk(not_esc == 0, "R1", "pulse one cycle", not_esc, 0);
    send(8'hD7);
    chk(not_esc == 1, "R1", "D7 below range", not_esc, 1);
    send(8'hE0);
    chk(not_esc == 1, "R1", "E0 above range", not_esc, 1);
    @(negedge clk);
  endtask

  task automatic t_reg_forms();
    do_insn(2, {8'hD8, 8'hC1, 32'h0}, 0, 1, 32'h0, "R3");
    for (int g = 0; g < 8; g++)
      do_insn(2, {8'hD8, 8'(8'hC0 + g*8 + (7-g)), 32'h0}, 0, 7-g, 32'h0, "R3");
  endtask

  task automatic t_mem_forms();
    for (int g = 0; g < 8; g++)
      do_insn(2, {8'hD8, 8'(g*8 + 1), 32'h0}, 1, 0, 32'h0, "R3");
  endtask

  task automatic t_load_double();
    do_insn(6, {8'hDD, 8'h05, 8'h04, 8'h00, 8'h00, 8'h00}, 1, 0, 32'h4, "R4");
    do_insn(6, {8'hD8, 8'h85, 8'h78, 8'h56, 8'h34, 8'h12}, 1, 0, 32'h12345678, "R7");
  endtask

  task automatic t_addr_bytes();
    do_insn(3, {8'hD8, 8'h48, 8'hF0, 24'h0}, 1, 0, 32'hFFFFFFF0, "R6");
    do_insn(3, {8'hD8, 8'h4B, 8'h7F, 24'h0}, 1, 0, 32'h0000007F, "R6");
    do_insn(4, {8'hD8, 8'h44, 8'h24, 8'h10, 16'h0}, 1, 0, 32'h10, "R6");
    do_insn(3, {8'hD8, 8'h3C, 8'h24, 24'h0}, 1, 0, 32'h0, "R6");
  endtask

  task automatic t_reserved();
    do_insn(6, {8'hD9, 8'h05, 8'hAA, 8'hBB, 8'hCC, 8'hDD}, 1, 0, 32'hDDCCBBAA, "R5");
    do_insn(2, {8'hDF, 8'hC3, 32'h0}, 0, 3, 32'h0, "R5");
    do_insn(2, {8'hDD, 8'h08, 32'h0}, 1, 0, 32'h0, "R5");
    do_insn(2, {8'hDD, 8'hC0, 32'h0}, 0, 0, 32'h0, "R5");
  endtask

  task automatic t_backpressure();
    send(8'hD8); send(8'hC2);
    in_byte = 8'h90; in_valid = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(in_ready == 0, "R9", "input stalled", in_ready, 0);
      chk(out_valid == 1 && out_op == 4'd1 && out_sti == 3'd2, "R9", "record held",
          {out_valid, out_op, out_sti}, {1'b1, 4'd1, 3'd2});
      chk(not_esc == 0, "R9", "stalled byte not consumed", not_esc, 0);
    end
    in_valid = 1'b0;
    take("R9");
  endtask

  task automatic t_mid_reset();
    send(8'hD8); send(8'h85); send(8'h11);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 0 && in_ready == 1, "R10", "partial discarded", {out_valid, in_ready}, 2'b01);
    do_insn(2, {8'hD8, 8'hC1, 32'h0}, 0, 1, 32'h0, "R10");
    send(8'h05);
    chk(not_esc == 1, "R10", "idle after reset", not_esc, 1);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_not_escape();
    t_reg_forms();
    t_mem_forms();
    t_load_double();
    t_addr_bytes();
    t_reserved();
    t_backpressure();
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule